// File: doc/BRIEF.md
# Half-line masking horizontal sync generator

This block turns a positive-going composite sync stream into a clean, active-low horizontal sync output with one pulse per full scan line. Besides the normal line sync pulses, a composite stream carries equalizing and serration pulses at half-line spacing during the vertical interval. A display that needs a separate horizontal drive must not see those extra pulses, and this block removes them.

Three one-shot timers make up the datapath. A restartable stretch timer widens each sync rise to a fixed length. That stretched pulse is gated by a mask, and the rising edge of the gated result fires two non-restartable timers. One forms the output pulse. The other closes the mask for a window a little longer than half a line, so any sync pulse that arrives in that window is dropped. A stretched pulse that overlaps the closed mask at any point stays blocked until it ends, so it cannot fire when the mask reopens partway through it. The sync input is taken as synchronous to the clock. Durations are given in nanoseconds together with the clock rate in kHz, and are rounded to the nearest whole cycle.

Top module: `line_sync_gate`

## Requirements
In what follows, STRETCH, MASK and PULSE are the stretch, mask and output durations in cycles. The sync input is active high. The hsync output is active low, and 1 means idle.
- R1: While reset is asserted, hsync_n_o is 1 and no sync activity drives it low. After reset the mask is open, so the first sync rise produces an output pulse.
- R2: When sync_i is sampled high at clock edge k after being sampled low at edge k-1, and the gate is open, hsync_n_o goes low after edge k+1.
- R3: Each output pulse holds hsync_n_o low for exactly PULSE cycles.
- R4: Sync rises spaced one full line apart (64 cycles in the bench) each produce exactly one output pulse.
- R5: If an output fires at edge t, a sync rise sampled at any edge up to t+MASK-1 produces no output pulse. This includes rises at half-line spacing.
- R6: A sync rise sampled at edge t+MASK or later, after the stretch from the previous pulse has ended, produces an output pulse.
- R7: A stretched pulse that was blocked by the mask in any cycle never produces an output, even if it is still active after the mask reopens.
- R8: In a vertical interval where half-line pulses replace normal lines, exactly one output appears per full line position, and none appears at the half-line positions in between.
- R9: Asserting reset in the middle of an output pulse returns hsync_n_o to 1 without waiting for a clock edge. It also reopens the mask, so the first rise after reset passes.
- R10: A sync input held high for longer than STRETCH produces exactly one output pulse of PULSE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sync_i | input | 1 | Positive-going composite sync, synchronous to clk_i |
| hsync_n_o | output | 1 | Horizontal sync, active low |

## Verification
The bench builds the block with CLK_KHZ set to 1000 while it actually runs it at 250 MHz. With that setting one cycle stands for one microsecond, so the stretch, mask and output windows become 8, 35 and 19 cycles, and a full line is 64 cycles. These short windows let the bench land sync rises exactly on the last blocked edge and the first open edge of the mask. They also let it place a half-line pulse that outlasts the mask, and run a complete vertical interval of half-line pulses within a few hundred cycles.

// File: rtl/line_sync_pkg.sv
package line_sync_pkg;

  typedef enum logic {
    RESTART_OFF = 1'b0,
    RESTART_ON  = 1'b1
  } restart_e;

  // Duration in ns at a clock of clk_khz kHz, rounded to the nearest cycle, minimum 1.
  function automatic int ns_to_cycles(input longint ns, input longint clk_khz);
    longint c;
    c = (ns * clk_khz + 64'sd500000) / 64'sd1000000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/ls_rise.sv
module ls_rise (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic d_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) prev_q <= 1'b0;
    else          prev_q <= d_i;
  end

  assign rise_o = d_i & ~prev_q;
endmodule

// File: rtl/ls_oneshot.sv
module ls_oneshot
  import line_sync_pkg::*;
#(
  parameter int       CYCLES = 8,
  parameter restart_e MODE   = RESTART_OFF
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic fire_i,
  output logic busy_o
);
  localparam int            CW   = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          load, en, running;

  assign running = (cnt_q != '0);

  generate
    if (MODE == RESTART_ON) begin : g_restart
      assign load = fire_i;
    end else begin : g_single
      assign load = fire_i & ~running;
    end
  endgenerate

  assign en = load | running;

  always_comb begin
    cnt_d = cnt_q;
    if (load)         cnt_d = LOAD;
    else if (running) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)  cnt_q <= '0;
    else if (en)   cnt_q <= cnt_d;
  end

  assign busy_o = running;

  // R3: without an accepted restart, an active timer counts down by exactly one
  p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (busy_o && !(fire_i && (MODE == RESTART_ON))) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R3: the count never exceeds the programmed length
  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cnt_q <= LOAD);
endmodule

// File: rtl/line_sync_gate.sv
module line_sync_gate
  import line_sync_pkg::*;
#(
  parameter int CLK_KHZ    = 250000,
  parameter int STRETCH_NS = 8000,
  parameter int MASK_NS    = 35000,
  parameter int PULSE_NS   = 18900
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic sync_i,
  output logic hsync_n_o
);
  localparam int STRETCH_CYC = ns_to_cycles(longint'(STRETCH_NS), longint'(CLK_KHZ));
  localparam int MASK_CYC    = ns_to_cycles(longint'(MASK_NS),    longint'(CLK_KHZ));
  localparam int PULSE_CYC   = ns_to_cycles(longint'(PULSE_NS),   longint'(CLK_KHZ));

  // Reset: asserted asynchronously, released after two clock edges
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic sync_rise, stretched, mask_act, pulse_act;
  logic gated, out_trig;
  logic blocked_q, blocked_d;

  ls_rise u_in_rise (
    .clk_i  (clk_i),
    .rst_n_i(rst_sync_n),
    .d_i    (sync_i),
    .rise_o (sync_rise)
  );

  ls_oneshot #(.CYCLES(STRETCH_CYC), .MODE(RESTART_ON)) u_stretch (
    .clk_i  (clk_i),
    .rst_n_i(rst_sync_n),
    .fire_i (sync_rise),
    .busy_o (stretched)
  );

  // A stretched pulse that meets the closed mask stays blocked until it ends
  always_comb begin
    blocked_d = stretched & (blocked_q | mask_act);
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) blocked_q <= 1'b0;
    else             blocked_q <= blocked_d;
  end

  assign gated = stretched & ~mask_act & ~blocked_q;

  ls_rise u_gate_rise (
    .clk_i  (clk_i),
    .rst_n_i(rst_sync_n),
    .d_i    (gated),
    .rise_o (out_trig)
  );

  ls_oneshot #(.CYCLES(MASK_CYC), .MODE(RESTART_OFF)) u_mask (
    .clk_i  (clk_i),
    .rst_n_i(rst_sync_n),
    .fire_i (out_trig),
    .busy_o (mask_act)
  );

  ls_oneshot #(.CYCLES(PULSE_CYC), .MODE(RESTART_OFF)) u_pulse (
    .clk_i  (clk_i),
    .rst_n_i(rst_sync_n),
    .fire_i (out_trig),
    .busy_o (pulse_act)
  );

  assign hsync_n_o = ~pulse_act;

  // R2: an output only starts while a stretched sync pulse is present
  p_fall_needs_stretch_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $fell(hsync_n_o) |-> $past(stretched));

  // R5: every output pulse closes the mask in the same cycle
  p_mask_opens_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $fell(hsync_n_o) |-> mask_act);

  // R7: a blocked stretched pulse never starts an output
  p_blocked_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    blocked_q |=> !$fell(hsync_n_o));

  // R1: idle output while reset is held
  always @(posedge clk_i) begin
    if (!rst_n_i) begin
      p_reset_idle_r1: assert (hsync_n_o);
    end
  end
endmodule

// File: tb/line_sync_gate_tb.sv
module line_sync_gate_tb;
  // Expected cycle counts at 1 cycle per microsecond: 8 us, 35 us, 18.9 us
  localparam int EXP_PULSE = 19;
  localparam int EXP_MASK  = 35;
  localparam int LINE      = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b0;
  logic hsync_n;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  line_sync_gate #(
    .CLK_KHZ(1000), .STRETCH_NS(8000), .MASK_NS(35000), .PULSE_NS(18900)
  ) u_dut (
    .clk_i    (clk),
    .rst_n_i  (rst_n),
    .sync_i   (sync),
    .hsync_n_o(hsync_n)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Output monitor: fall cycle and low width of each pulse
  int  fall_q[$];
  int  width_q[$];
  int  last_fall = 0;
  logic prev_h = 1'b1;
  always @(negedge clk) begin
    if (prev_h && !hsync_n) begin
      fall_q.push_back(cyc);
      last_fall = cyc;
    end
    if (!prev_h && hsync_n) width_q.push_back(cyc - last_fall);
    prev_h = hsync_n;
  end

  task automatic check_int(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_at(input int edge_n, input int w);
    while (cyc < edge_n - 1) @(negedge clk);
    sync = 1'b1;
    repeat (w) @(negedge clk);
    sync = 1'b0;
  endtask

  task automatic begin_case(output int base);
    @(negedge clk);
    fall_q.delete();
    width_q.delete();
    base = cyc + 3;
  endtask

  task automatic t_reset();
    int bad = 0;
    for (int i = 0; i < 30; i++) begin
      sync = (i % 7) < 3;
      @(negedge clk);
      if (hsync_n !== 1'b1) bad++;
    end
    sync = 1'b0;
    check_int("R1 idle during reset", bad, 0);
    check_int("R1 no pulse during reset", fall_q.size(), 0);
    rst_n = 1'b1;
    idle(5);
    check_int("R1 idle after reset", int'(hsync_n), 1);
  endtask

  task automatic t_first();
    int base;
    begin_case(base);
    pulse_at(base, 5);
    idle(40);
    check_int("R1 first pulse passes", fall_q.size(), 1);
    if (fall_q.size() == 1) check_int("R2 fall cycle", fall_q[0], base + 1);
    if (width_q.size() == 1) check_int("R3 width", width_q[0], EXP_PULSE);
  endtask

  task automatic t_lines();
    int base;
    begin_case(base);
    for (int i = 0; i < 4; i++) pulse_at(base + LINE * i, 5);
    idle(40);
    check_int("R4 one per line", fall_q.size(), 4);
    for (int i = 0; i < 4 && i < fall_q.size(); i++)
      check_int("R4 line fall", fall_q[i], base + LINE * i + 1);
  endtask

  task automatic t_half();
    int base;
    begin_case(base);
    pulse_at(base, 5);
    pulse_at(base + 20, 2);
    pulse_at(base + 32, 2);
    idle(50);
    check_int("R5 half-line rejected", fall_q.size(), 1);
  endtask

  task automatic t_edge_closed();
    int base;
    begin_case(base);
    pulse_at(base, 5);
    pulse_at(base + EXP_MASK, 2); // last blocked edge: t+MASK-1 with t=base+1
    idle(50);
    check_int("R5 last closed edge rejected", fall_q.size(), 1);
  endtask

  task automatic t_edge_open();
    int base;
    begin_case(base);
    pulse_at(base, 5);
    pulse_at(base + EXP_MASK + 1, 2); // first open edge: t+MASK
    idle(50);
    check_int("R6 first open edge passes", fall_q.size(), 2);
    if (fall_q.size() == 2) check_int("R6 fall cycle", fall_q[1], base + EXP_MASK + 2);
  endtask

  task automatic t_overlap();
    int base;
    begin_case(base);
    pulse_at(base, 5);
    pulse_at(base + 34, 2); // stretch runs past the mask end
    idle(50);
    check_int("R7 overlapped stretch blocked", fall_q.size(), 1);
  endtask

  task automatic t_vertical();
    int base;
    int exp_n = 0;
    begin_case(base);
    for (int i = 0; i < 3; i++) pulse_at(base + LINE * i, 5);
    for (int i = 5; i < 12; i++) pulse_at(base + 32 * i, 2);
    for (int i = 6; i < 8; i++) pulse_at(base + LINE * i, 5);
    idle(50);
    check_int("R8 count in vertical interval", fall_q.size(), 8);
    foreach (fall_q[i]) begin
      check_int("R8 full-line position", fall_q[i], base + LINE * exp_n + 1);
      exp_n++;
    end
  endtask

  task automatic t_wide();
    int base;
    begin_case(base);
    pulse_at(base, 12);
    idle(50);
    check_int("R10 wide sync single pulse", fall_q.size(), 1);
    if (width_q.size() == 1) check_int("R10 width", width_q[0], EXP_PULSE);
  endtask

  task automatic t_reset_mid();
    int base;
    begin_case(base);
    pulse_at(base, 5);
    check_int("R9 pulse active before reset", int'(hsync_n), 0);
    #1 rst_n = 1'b0;
    #1 check_int("R9 async clear", int'(hsync_n), 1);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    begin_case(base);
    pulse_at(base, 5);
    idle(40);
    check_int("R9 mask reopened by reset", fall_q.size(), 1);
    if (fall_q.size() == 1) check_int("R9 fall cycle", fall_q[0], base + 1);
  endtask

  initial begin
    t_reset();
    t_first();
    t_lines();
    t_half();
    t_edge_closed();
    t_edge_open();
    t_overlap();
    t_vertical();
    t_wide();
    t_reset_mid();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule